// File: doc/BRIEF.md
# Logging Session Controller

This block keeps the control and status flags that govern one logging session of an event recorder. A host reaches it through a plain register bus: address, write data, a write strobe and a read strobe, each access taking one cycle. A session (a "mission") can be started by a register write or by an external trigger. It is stopped by an explicit write, and it is also stopped by any other write that lands while it runs. A session may begin only after the log storage has been verifiably cleared. The clear is protected: it must first be armed in one write and then fired in a later write.

While the clear runs, the block raises a busy output for a fixed number of cycles set by a parameter, and it ignores every bus access. At the start of the clear it sends a single-cycle request pulse to the log memory. An alarm flag is set by a time-match input from the timekeeping logic. The flag clears whenever the host reads or writes any alarm register byte. No data streams through the block, so every pin is a plain control or status level or pulse, with no valid/ready handshake.

Register layout, with a 4-bit address:
- 0x0, control: bit 0 is session enable, bit 1 is clear arm, bit 2 is clear fire.
- 0x1, session: bit 0 writes start (1) or stop (0).
- 0x8 to 0xB: the four alarm bytes.
- Every other address stands for timekeeping or memory locations. A write there has no effect here except that it stops a running session.

Top module: `logsess_ctrl`

## Requirements
- R1: On synchronous reset, mission_active, mission_en, clear_busy, clear_req and alarm_flag are 0 and mem_cleared is 1.
- R2: With mission_en = 1 and mem_cleared = 1, a cycle with trig high and no write sets mission_active on the next clock edge and drops mem_cleared. With mission_en = 0, trig has no effect.
- R3: Writing 1 to bit 0 of address 0x1 sets mission_active and mission_en and clears mem_cleared, but only when mem_cleared is 1. Otherwise the write starts nothing.
- R4: Writing 0 to bit 0 of address 0x1 clears both mission_active and mission_en.
- R5: Any write to any address while mission_active is 1 clears mission_active. Since mem_cleared stays 0, a later trigger cannot restart the session.
- R6: Writing 1 to the fire bit (bit 2 of address 0x0) starts a clear only if the arm bit (bit 1 of 0x0) was already 1 before that write. A single write that sets arm and fire together starts nothing and leaves the block armed.
- R7: A clear sends clear_req high for exactly one cycle and clears mem_cleared. It holds clear_busy high for exactly CLR_CYCLES cycles. When it ends, mem_cleared returns to 1 and the arm bit returns to 0, so a fire write with no new arm does nothing.
- R8: While clear_busy is 1, all reads and writes are ignored. They do not start, stop or arm anything, and they do not clear alarm_flag.
- R9: alarm_flag is set on the edge after time_match is high. It is cleared by a read or write to any address 0x8 to 0xB. An access to any other address leaves it set, and a match in the same cycle as an access takes priority.
- R10: A fire write while osc_en is 0 starts no clear, even when the block is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| wr | input | 1 | Write strobe, one access per cycle |
| rd | input | 1 | Read strobe |
| trig | input | 1 | External session trigger, level |
| osc_en | input | 1 | Oscillator running; gates the clear |
| time_match | input | 1 | Time equals alarm setting |
| mission_active | output | 1 | Session in progress |
| mission_en | output | 1 | Session enable |
| mem_cleared | output | 1 | Log storage verified clear |
| clear_busy | output | 1 | Clear in progress; bus ignored |
| clear_req | output | 1 | One-cycle clear request to log memory |
| alarm_flag | output | 1 | Alarm match flag |

## Verification
Every flag is one register deep. A write, trigger or match that is present at clock edge k shows its result right after edge k, so the bench drives each stimulus for one cycle from a falling edge and samples on the next falling edge. clear_req is checked at that same sample point, and is checked to be low again one falling edge later. clear_busy is counted on consecutive falling edges, starting at the sample that follows the fire write, and the count must equal CLR_CYCLES exactly. mem_cleared is checked on the falling edge where busy is first seen low.

// File: rtl/logsess_pkg.sv
package logsess_pkg;
  // register addresses
  localparam int REG_CTRL  = 0;
  localparam int REG_SESS  = 1;
  localparam int ALM_FIRST = 8;
  localparam int ALM_LAST  = 11;
  // bit positions
  localparam int CTRL_EN   = 0;
  localparam int CTRL_ARM  = 1;
  localparam int CTRL_FIRE = 2;
  localparam int SESS_RUN  = 0;

  typedef struct packed {
    logic wr_any;
    logic wr_ctrl;
    logic wr_sess;
    logic alm_touch;
  } acc_t;
endpackage

// File: rtl/logsess_clear_seq.sv
module logsess_clear_seq #(
  parameter int CLR_CYCLES = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic arm_bit,
  input  logic fire_bit,
  input  logic osc_en,
  output logic busy,
  output logic req,
  output logic start,
  output logic done
);
  localparam int CNT_W = $clog2(CLR_CYCLES + 1);

  logic             arm;
  logic [CNT_W-1:0] cnt;

  // fire honoured only on the arm state held before this write
  assign start = ctrl_wr && fire_bit && arm && osc_en && !busy;
  assign done  = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      arm  <= 1'b0;
      busy <= 1'b0;
      cnt  <= '0;
      req  <= 1'b0;
    end else begin
      req <= start;
      if (start) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(CLR_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
      if (done)         arm <= 1'b0;
      else if (ctrl_wr) arm <= arm_bit;
    end
  end

  // length of busy window, tracked for the checks below
  logic [CNT_W:0] busy_len;
  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  assert_fire_needs_arm_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(arm));
  assert_osc_gate_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(osc_en));
  assert_req_single_R7: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
  assert_req_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
    req |-> busy);
  assert_busy_length_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == (CNT_W+1)'(CLR_CYCLES)));
  assert_arm_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !arm);
endmodule

// File: rtl/logsess_mission.sv
module logsess_mission (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic wr_any,
  input  logic wr_ctrl,
  input  logic en_bit,
  input  logic wr_sess,
  input  logic run_bit,
  input  logic clr_start,
  input  logic clr_done,
  output logic active,
  output logic en,
  output logic mem_clr
);
  logic sw_start, hw_start, go, sw_stop, abort;

  assign sw_start = wr_sess && run_bit && mem_clr && !active;
  assign hw_start = trig && en && mem_clr && !active && !wr_any;
  assign go       = sw_start || hw_start;
  assign sw_stop  = wr_sess && !run_bit;
  assign abort    = active && wr_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      en      <= 1'b0;
      mem_clr <= 1'b1;
    end else begin
      if (go)                    active <= 1'b1;
      else if (abort || sw_stop) active <= 1'b0;

      if (sw_start)     en <= 1'b1;
      else if (sw_stop) en <= 1'b0;
      else if (wr_ctrl) en <= en_bit;

      if (go || clr_start) mem_clr <= 1'b0;
      else if (clr_done)   mem_clr <= 1'b1;
    end
  end

  assert_trig_start_R2: assert property (@(posedge clk) disable iff (rst)
    (trig && en && mem_clr && !wr_any) |=> active);
  assert_start_needs_clear_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(mem_clr));
  assert_run_not_clear_R2: assert property (@(posedge clk) disable iff (rst)
    active |-> !mem_clr);
  assert_stop_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_sess && !run_bit) |=> (!active && !en));
  assert_abort_R5: assert property (@(posedge clk) disable iff (rst)
    (active && wr_any) |=> !active);
  assert_done_sets_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr_done |=> mem_clr);
endmodule

// File: rtl/logsess_alarm.sv
module logsess_alarm (
  input  logic clk,
  input  logic rst,
  input  logic time_match,
  input  logic touch,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)             flag <= 1'b0;
    else if (time_match) flag <= 1'b1;
    else if (touch)      flag <= 1'b0;
  end

  assert_match_sets_R9: assert property (@(posedge clk) disable iff (rst)
    time_match |=> flag);
  assert_touch_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (touch && !time_match) |=> !flag);
endmodule

// File: rtl/logsess_ctrl.sv
module logsess_ctrl
  import logsess_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int CLR_CYCLES = 125000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic              trig,
  input  logic              osc_en,
  input  logic              time_match,
  output logic              mission_active,
  output logic              mission_en,
  output logic              mem_cleared,
  output logic              clear_busy,
  output logic              clear_req,
  output logic              alarm_flag
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_SESS = ADDR_W'(REG_SESS);
  localparam logic [ADDR_W-1:0] A_ALO  = ADDR_W'(ALM_FIRST);
  localparam logic [ADDR_W-1:0] A_AHI  = ADDR_W'(ALM_LAST);

  acc_t acc;
  logic clr_start, clr_done;

  // every access is dropped while the clear runs
  always_comb begin
    acc.wr_any    = wr && !clear_busy;
    acc.wr_ctrl   = acc.wr_any && (addr == A_CTRL);
    acc.wr_sess   = acc.wr_any && (addr == A_SESS);
    acc.alm_touch = (wr || rd) && !clear_busy && (addr >= A_ALO) && (addr <= A_AHI);
  end

  logsess_clear_seq #(.CLR_CYCLES(CLR_CYCLES)) u_clear (
    .clk      (clk),
    .rst      (rst),
    .ctrl_wr  (acc.wr_ctrl),
    .arm_bit  (wdata[CTRL_ARM]),
    .fire_bit (wdata[CTRL_FIRE]),
    .osc_en   (osc_en),
    .busy     (clear_busy),
    .req      (clear_req),
    .start    (clr_start),
    .done     (clr_done)
  );

  logsess_mission u_mission (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig),
    .wr_any    (acc.wr_any),
    .wr_ctrl   (acc.wr_ctrl),
    .en_bit    (wdata[CTRL_EN]),
    .wr_sess   (acc.wr_sess),
    .run_bit   (wdata[SESS_RUN]),
    .clr_start (clr_start),
    .clr_done  (clr_done),
    .active    (mission_active),
    .en        (mission_en),
    .mem_clr   (mem_cleared)
  );

  logsess_alarm u_alarm (
    .clk        (clk),
    .rst        (rst),
    .time_match (time_match),
    .touch      (acc.alm_touch),
    .flag       (alarm_flag)
  );

  assert_busy_keeps_alarm_R8: assert property (@(posedge clk) disable iff (rst)
    (clear_busy && alarm_flag) |=> alarm_flag);
  assert_busy_keeps_enable_R8: assert property (@(posedge clk) disable iff (rst)
    clear_busy |=> $stable(mission_en));
  assert_busy_no_session_R8: assert property (@(posedge clk) disable iff (rst)
    clear_busy |=> !mission_active);
endmodule

// File: tb/logsess_ctrl_tb.sv
module logsess_ctrl_tb;
  localparam int CLR = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0, trig = 1'b0, osc_en = 1'b1, time_match = 1'b0;
  logic       mission_active, mission_en, mem_cleared, clear_busy, clear_req, alarm_flag;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  logsess_ctrl #(.ADDR_W(4), .DATA_W(8), .CLR_CYCLES(CLR)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .trig(trig), .osc_en(osc_en), .time_match(time_match),
    .mission_active(mission_active), .mission_en(mission_en),
    .mem_cleared(mem_cleared), .clear_busy(clear_busy),
    .clear_req(clear_req), .alarm_flag(alarm_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && clear_busy; i++) @(negedge clk);
  endtask

  task automatic do_clear();
    bus_wr(4'h0, 8'h02);
    bus_wr(4'h0, 8'h06);
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R1 active", mission_active, 0);
    chk("R1 enable", mission_en, 0);
    chk("R1 cleared", mem_cleared, 1);
    chk("R1 busy", clear_busy, 0);
    chk("R1 req", clear_req, 0);
    chk("R1 alarm", alarm_flag, 0);
  endtask

  task automatic t_clear();
    int n = 0;
    bus_wr(4'h0, 8'h02);
    bus_wr(4'h0, 8'h06);
    chk("R7 req high", clear_req, 1);
    chk("R7 busy high", clear_busy, 1);
    chk("R7 cleared low", mem_cleared, 0);
    while (clear_busy && n < 1000) begin
      n++;
      if (n == 2) chk("R7 req single", clear_req, 0);
      @(negedge clk);
    end
    chk("R7 busy length", n, CLR);
    chk("R7 cleared back", mem_cleared, 1);
    bus_wr(4'h0, 8'h04);
    chk("R7 arm dropped", clear_busy, 0);
  endtask

  task automatic t_same_write();
    bus_wr(4'h0, 8'h06);
    chk("R6 same write", clear_busy, 0);
    bus_wr(4'h0, 8'h04);
    chk("R6 armed earlier", clear_busy, 1);
    wait_idle();
  endtask

  task automatic t_osc();
    osc_en = 1'b0;
    bus_wr(4'h0, 8'h02);
    bus_wr(4'h0, 8'h06);
    chk("R10 osc off", clear_busy, 0);
    osc_en = 1'b1;
    bus_wr(4'h0, 8'h06);
    chk("R10 osc on", clear_busy, 1);
    wait_idle();
  endtask

  task automatic t_busy_ignore();
    @(negedge clk); time_match = 1'b1;
    @(negedge clk); time_match = 1'b0;
    chk("R9 match set", alarm_flag, 1);
    bus_wr(4'h0, 8'h02);
    bus_wr(4'h0, 8'h06);
    bus_wr(4'h1, 8'h01);
    bus_rd(4'h9);
    bus_wr(4'h0, 8'h03);
    chk("R8 alarm kept", alarm_flag, 1);
    chk("R8 enable kept", mission_en, 0);
    wait_idle();
    chk("R8 no start", mission_active, 0);
    bus_wr(4'h0, 8'h04);
    chk("R8 arm not set", clear_busy, 0);
    bus_rd(4'hA);
    chk("R9 read clears", alarm_flag, 0);
  endtask

  task automatic t_sw_start();
    bus_wr(4'h1, 8'h01);
    chk("R3 start active", mission_active, 1);
    chk("R3 start enable", mission_en, 1);
    chk("R3 cleared drop", mem_cleared, 0);
    bus_wr(4'h1, 8'h00);
    chk("R4 stop active", mission_active, 0);
    chk("R4 stop enable", mission_en, 0);
    bus_wr(4'h1, 8'h01);
    chk("R3 needs clear", mission_active, 0);
  endtask

  task automatic t_trigger();
    do_clear();
    bus_wr(4'h0, 8'h00);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    chk("R2 no enable", mission_active, 0);
    bus_wr(4'h0, 8'h01);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    chk("R2 trig start", mission_active, 1);
    chk("R2 cleared drop", mem_cleared, 0);
  endtask

  task automatic t_abort();
    bus_wr(4'h5, 8'h00);
    chk("R5 abort", mission_active, 0);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    chk("R5 no restart", mission_active, 0);
  endtask

  task automatic t_alarm();
    @(negedge clk); time_match = 1'b1;
    @(negedge clk); time_match = 1'b0;
    bus_rd(4'h3);
    chk("R9 other addr", alarm_flag, 1);
    bus_wr(4'hB, 8'h00);
    chk("R9 write clears", alarm_flag, 0);
    @(negedge clk); time_match = 1'b1; addr = 4'h8; rd = 1'b1;
    @(negedge clk); time_match = 1'b0; rd = 1'b0;
    chk("R9 match wins", alarm_flag, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clear();
    t_same_write();
    t_osc();
    t_busy_ignore();
    t_sw_start();
    t_trigger();
    t_abort();
    t_alarm();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule